// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two unsigned words one bit position per clock, starting with the least significant bit. Each operand sits in its own shift register. A single full-adder cell combines the two bits leaving the bottom of the registers with a stored carry bit. The resulting sum bit is written into the vacated top position of the augend register. After one shift per bit position, the augend register holds the sum and the carry flip-flop holds the carry out of the word.

The addend register has two modes. It can rotate its own bits, so the addend is unchanged after a full word and can be added again. It can also take a fresh bit from a serial input on every shift, so the next operand streams in while the current one is consumed.

A typical use starts with one cycle that loads both operands and clears the carry. Shift-enable is then held high for one cycle per bit. The result is read from the parallel sum output once the done flag rises.

Top module: `serial_adder_top`

## Requirements
- R1: After reset, `sum_out`, `carry_out` and `done` are all 0.
- R2: In a cycle with `load` high, the augend register takes `a_in`, the addend register takes `b_in` and the shift counter returns to 0. This happens whether or not `shift_en` is high, and no shift occurs in that cycle.
- R3: On each shift, every augend bit moves one position toward bit 0. Bit WIDTH-1 receives the XOR of the old augend bit 0, the old addend bit 0 and the old carry.
- R4: On each shift, the carry becomes 1 when at least two of these three bits were 1: old augend bit 0, old addend bit 0 and old carry. Otherwise the carry becomes 0.
- R5: After a load with the carry cleared, followed by WIDTH shifts, `sum_out` equals (a+b) mod 2^WIDTH and `carry_out` equals bit WIDTH of a+b.
- R6: A cycle with `shift_en`, `load` and `carry_clr` all low leaves `sum_out`, `carry_out` and `done` unchanged.
- R7: `carry_clr` forces the carry to 0 and the shift counter to 0 on the next edge. No shift occurs in that cycle.
- R8: With `b_recirc` = 1, each shift moves the addend's bit 0 into its bit WIDTH-1. After WIDTH shifts the addend is restored.
- R9: With `b_recirc` = 0, each shift moves `b_ser_in` into bit WIDTH-1 of the addend. After WIDTH shifts the addend equals the serial bits, the first bit sent ending up at bit 0.
- R10: `done` is high exactly when WIDTH shifts have occurred since the last load or carry clear. It stays high through further shifts until the next load or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Parallel load of both operands |
| carry_clr | input | 1 | Synchronous clear of carry and shift counter |
| shift_en | input | 1 | Perform one serial add step |
| b_recirc | input | 1 | 1: addend rotates; 0: addend takes `b_ser_in` |
| b_ser_in | input | 1 | Serial data for the addend top bit |
| a_in | input | WIDTH | Augend parallel load value |
| b_in | input | WIDTH | Addend parallel load value |
| sum_out | output | WIDTH | Augend/sum register contents |
| carry_out | output | 1 | Stored carry |
| done | output | 1 | WIDTH shifts completed since load/clear |

## Verification
The hardest state to reach is an addend whose contents came from the serial input or from rotation. The addend is never visible at the ports. The bench reaches it by running a full word in one addend mode, clearing only the carry, and running a second word. The second sum then shows the addend that the first pass left behind. Reaching a carry-producing sum and then pulsing only the clear makes the clear observable alone.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;

    typedef enum logic {
        ADDEND_SERIAL = 1'b0,
        ADDEND_RECIRC = 1'b1
    } addend_mode_e;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/sa_full_add.sv
module sa_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    import serial_adder_pkg::*;

    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = maj3(x_i, y_i, c_i);
    end
endmodule

// File: rtl/sa_shreg.sv
module sa_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load_i) begin
            data_d = par_i;
        end else if (shift_i) begin
            data_d = {ser_i, data_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign q_o = data_q;
endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             carry_clr,
    input  logic             shift_en,
    input  logic             b_recirc,
    input  logic             b_ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             done
);
    import serial_adder_pkg::*;

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIDTH);

    typedef struct packed {
        logic             carry;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             shift_act;
    logic [WIDTH-1:0] augend_q, addend_q;
    logic             fa_sum, fa_carry, addend_feed;
    addend_mode_e     mode;

    assign mode      = addend_mode_e'(b_recirc);
    assign shift_act = shift_en & ~load & ~carry_clr;

    sa_full_add u_fa (
        .x_i (augend_q[0]),
        .y_i (addend_q[0]),
        .c_i (ctl_q.carry),
        .s_o (fa_sum),
        .c_o (fa_carry)
    );

    always_comb begin
        addend_feed = (mode == ADDEND_RECIRC) ? addend_q[0] : b_ser_in;
    end

    sa_shreg #(.WIDTH(WIDTH)) u_augend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift_act),
        .par_i   (a_in),
        .ser_i   (fa_sum),
        .q_o     (augend_q)
    );

    sa_shreg #(.WIDTH(WIDTH)) u_addend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift_act),
        .par_i   (b_in),
        .ser_i   (addend_feed),
        .q_o     (addend_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (carry_clr) begin
            ctl_d.carry = 1'b0;
            ctl_d.cnt   = '0;
        end
        if (load) begin
            ctl_d.cnt = '0;
        end
        if (shift_act) begin
            ctl_d.carry = fa_carry;
            if (ctl_q.cnt != CNT_MAX) ctl_d.cnt = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sum_out   = augend_q;
    assign carry_out = ctl_q.carry;
    assign done      = (ctl_q.cnt == CNT_MAX);
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             carry_clr,
    input logic             shift_en,
    input logic             b_recirc,
    input logic             b_ser_in,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             done,
    input logic [WIDTH-1:0] addend_q
);
    logic shifting;
    assign shifting = shift_en & ~load & ~carry_clr;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sum_out == $past(a_in)) && (addend_q == $past(b_in)) && !done);

    assert_sum_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |=> sum_out[WIDTH-1] ==
            ($past(sum_out[0]) ^ $past(addend_q[0]) ^ $past(carry_out)));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |=> sum_out[WIDTH-2:0] == $past(sum_out[WIDTH-1:1]));

    assert_carry_maj_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |=> carry_out ==
            (($past(sum_out[0]) + $past(addend_q[0]) + $past(carry_out)) >= 2'd2));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load && !carry_clr) |=>
            $stable(sum_out) && $stable(carry_out) && $stable(done));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry_clr |=> !carry_out && !done);

    assert_clear_noshift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_clr && !load) |=> $stable(sum_out));

    assert_recirc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && b_recirc) |=> addend_q[WIDTH-1] == $past(addend_q[0]));

    assert_serial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && !b_recirc) |=> addend_q[WIDTH-1] == $past(b_ser_in));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load && !carry_clr) |=> done);
endmodule

bind serial_adder_top serial_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .carry_clr (carry_clr),
    .shift_en  (shift_en),
    .b_recirc  (b_recirc),
    .b_ser_in  (b_ser_in),
    .a_in      (a_in),
    .b_in      (b_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .done      (done),
    .addend_q  (addend_q)
);

// File: tb/serial_adder_top_tb.sv
`timescale 1ns/1ps
module serial_adder_top_tb;
    localparam int W = 4;
    localparam int NV = 8;
    // {a, b, sum, cout}
    localparam logic [12:0] VEC [NV] = '{
        {4'd3,  4'd5,  4'd8,  1'b0},
        {4'd15, 4'd1,  4'd0,  1'b1},
        {4'd9,  4'd9,  4'd2,  1'b1},
        {4'd0,  4'd0,  4'd0,  1'b0},
        {4'd7,  4'd8,  4'd15, 1'b0},
        {4'd10, 4'd6,  4'd0,  1'b1},
        {4'd12, 4'd12, 4'd8,  1'b1},
        {4'd5,  4'd10, 4'd15, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic load = 0, carry_clr = 0, shift_en = 0, b_recirc = 1, b_ser_in = 0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] sum_out;
    logic carry_out, done;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_adder_top #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .carry_clr(carry_clr),
        .shift_en(shift_en), .b_recirc(b_recirc), .b_ser_in(b_ser_in),
        .a_in(a_in), .b_in(b_in), .sum_out(sum_out),
        .carry_out(carry_out), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic start(input logic [W-1:0] a, input logic [W-1:0] b);
        load = 1; carry_clr = 1; a_in = a; b_in = b;
        tick();
        load = 0; carry_clr = 0;
    endtask

    task automatic shifts(input int n);
        shift_en = 1;
        for (int i = 0; i < n; i++) tick();
        shift_en = 0;
    endtask

    initial begin
        #20000;
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 reset state
        check("R1 sum", sum_out, 0);
        check("R1 carry", carry_out, 0);
        check("R1 done", done, 0);
        rst_n = 1;

        // R5 R3 R4 R10 table walk
        for (int v = 0; v < NV; v++) begin
            start(VEC[v][12:9], VEC[v][8:5]);
            check("R2 load a", sum_out, VEC[v][12:9]);
            shifts(W - 1);
            check("R10 not done early", done, 0);
            shifts(1);
            check("R5 sum", sum_out, VEC[v][4:1]);
            check("R5 R4 carry", carry_out, VEC[v][0]);
            check("R10 done", done, 1);
        end

        // R3 single step: a=1,b=1,c=0 -> sum bit 0 to top, carry 1
        start(4'd1, 4'd1);
        shifts(1);
        check("R3 step", sum_out, 0);
        check("R4 step carry", carry_out, 1);

        // R6 hold mid-addition
        start(4'd6, 4'd7);
        shifts(2);
        begin
            logic [W-1:0] s; logic c;
            s = sum_out; c = carry_out;
            tick(); tick(); tick();
            check("R6 hold sum", sum_out, s);
            check("R6 hold carry", carry_out, c);
            check("R6 hold done", done, 0);
        end
        shifts(2);
        check("R6 resume sum", sum_out, 13);
        check("R10 done after 4 shifts", done, 1);
        shifts(2);
        check("R10 done stays", done, 1);

        // R2 load priority over shift
        a_in = 4'd9; b_in = 4'd2; load = 1; shift_en = 1;
        tick();
        load = 0; shift_en = 0;
        check("R2 load priority", sum_out, 9);
        check("R2 count reset", done, 0);

        // R7 carry clear alone, shift suppressed
        start(4'd8, 4'd8);
        shifts(4);
        check("R7 pre carry", carry_out, 1);
        carry_clr = 1; shift_en = 1;
        tick();
        carry_clr = 0; shift_en = 0;
        check("R7 carry cleared", carry_out, 0);
        check("R7 done cleared", done, 0);
        check("R7 no shift", sum_out, 0);

        // R8 recirculation keeps addend: 2+5=7, then 7+5=12
        b_recirc = 1;
        start(4'd2, 4'd5);
        shifts(4);
        check("R8 first", sum_out, 7);
        carry_clr = 1; tick(); carry_clr = 0;
        shifts(4);
        check("R8 second uses same addend", sum_out, 12);

        // R9 serial addend: stream 6 (LSB first) while adding 3+5
        start(4'd3, 4'd5);
        b_recirc = 0;
        shift_en = 1;
        for (int i = 0; i < W; i++) begin
            b_ser_in = 1'((6 >> i) & 1);
            tick();
        end
        shift_en = 0; b_ser_in = 0;
        check("R9 first sum", sum_out, 8);
        b_recirc = 1;
        carry_clr = 1; tick(); carry_clr = 0;
        shifts(4);
        check("R9 streamed addend", sum_out, 14);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule